// File: doc/BRIEF.md
# Operand Addressing Extension Decoder

This block turns the addressing fields of an instruction into a resolved operand descriptor. It takes a 3-bit addressing mode, a 3-bit register number and an operand size, then pulls zero, one or two 16-bit extension words from the instruction stream through a ready/valid handshake. How many words it pulls depends on the mode and, for immediate operands, on the size.

When the last word has been taken, the block pulses `done_o` for one cycle. The descriptor is then available: an operand kind code, the base register, a 32-bit value (a sign-extended displacement, an absolute address or immediate data), and the index-register selection fields unpacked from a brief index word. A combination that has no legal meaning completes without pulling any words and raises `err_o`. The block neither forms addresses nor reads registers.

The controller has four states:
- `ST_IDLE` waits for a start.
- `ST_WORD_A` takes the first extension word.
- `ST_WORD_B` takes the second word of a 32-bit value.
- `ST_DONE` presents the finished descriptor.

Transitions:
- `ST_IDLE` goes to `ST_DONE` on a start that needs no words or is illegal.
- `ST_IDLE` goes to `ST_WORD_A` on any other start.
- `ST_WORD_A` goes to `ST_WORD_B` on a taken word when two words are needed.
- `ST_WORD_A` goes to `ST_DONE` on a taken word when only one is needed.
- `ST_WORD_B` goes to `ST_DONE` on a taken word.
- `ST_DONE` always returns to `ST_IDLE`.

Top module: `ea_ext_decoder`

## Requirements
- R1: Reset state.
  - `done_o`, `ext_ready_o` and `err_o` are 0.
  - `kind_o` is 15 (none).
  - `value_o`, `base_reg_o` and all index fields are 0.
- R2: Modes 0 to 4 pull no words and pulse `done_o` in the cycle after the start is sampled. For these modes:
  - `kind_o` equals the mode (0 data direct, 1 address direct, 2 indirect, 3 post-increment, 4 pre-decrement).
  - `base_reg_o` is the register number.
  - `value_o` is 0.
- R3: Mode 5 pulls one word and sign-extends it from 16 to 32 bits. `kind_o` is 5 and `base_reg_o` is the register number.
- R4: Mode 6 pulls one brief index word. `kind_o` is 6 and `base_reg_o` is the register number. The fields are:
  - Bit 15 gives `idx_is_addr_o` (0 data, 1 address register).
  - Bits 14:12 give `idx_reg_o`.
  - Bit 11 gives `idx_long_o` (0 word, 1 long).
  - Bits 7:0 are sign-extended to 32 bits into `value_o`.
- R5: Mode 7, register 0 pulls one word and sign-extends it to a 32-bit absolute address (`kind_o` 7). Register 1 pulls two words, the first forming bits 31:16 and the second bits 15:0 (`kind_o` 8). For all mode-7 forms, `base_reg_o` is 0.
- R6: Mode 7, register 2 pulls one word, sign-extended as a PC-relative displacement (`kind_o` 9). Register 3 pulls one brief index word, decoded as in R4 (`kind_o` 10).
- R7: Mode 7, register 4 is immediate data (`kind_o` 11). The size code is 0 byte, 1 word, 2 long, 3 none.
  - For byte or word size, one word is pulled and zero-extended.
  - For long size, two words are pulled, high word first.
- R8: The illegal combinations are mode 7 with register 5, 6 or 7, and mode 7 register 4 with size 3. Each completes with `err_o` = 1 and `kind_o` = 15, never raises `ext_ready_o`, and pulls no words.
- R9: `done_o` is high for exactly one cycle per operation. After it, the descriptor holds its values until the next start is accepted.
- R10: A start that arrives while an operation is in progress is ignored. It does not change the descriptor of the running operation.
- R11: A word is taken only in a cycle where `ext_ready_o` and `ext_valid_i` are both high. While `ext_valid_i` is low, the block waits indefinitely with `ext_ready_o` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin decoding; sampled only when idle |
| mode_i | input | 3 | Addressing mode |
| reg_i | input | 3 | Register number field |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2 long, 3 none |
| ext_valid_i | input | 1 | Extension word on `ext_data_i` is valid |
| ext_data_i | input | WORD_W | Extension word |
| ext_ready_o | output | 1 | Block will take an extension word this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Illegal combination (valid from `done_o` onward) |
| kind_o | output | 4 | Operand kind code |
| base_reg_o | output | 3 | Base register number |
| value_o | output | 2*WORD_W | Displacement, absolute address or immediate data |
| idx_is_addr_o | output | 1 | Index register is an address register |
| idx_reg_o | output | 3 | Index register number |
| idx_long_o | output | 1 | Index used at long size |

## Verification
The bench builds the block with its default word width of 16 bits, which gives a 32-bit value. At that width, sign extension from bit 15 and from bit 7 can be told apart from zero extension by choosing words with the top bit set. The high-first assembly of two-word values is visible in the upper and lower halves of `value_o`. Stalled handshakes and starts injected mid-operation reach the waiting and ignoring paths of the controller.

// File: rtl/ea_ext_pkg.sv
package ea_ext_pkg;

    typedef enum logic [3:0] {
        K_DREG    = 4'd0,
        K_AREG    = 4'd1,
        K_IND     = 4'd2,
        K_POSTINC = 4'd3,
        K_PREDEC  = 4'd4,
        K_DISP    = 4'd5,
        K_INDEX   = 4'd6,
        K_ABS16   = 4'd7,
        K_ABS32   = 4'd8,
        K_PCDISP  = 4'd9,
        K_PCINDEX = 4'd10,
        K_IMM     = 4'd11,
        K_NONE    = 4'd15
    } ea_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_NONE = 2'd3
    } op_size_e;

    // How the first extension word is folded into the value
    typedef enum logic [1:0] {
        FMT_SEXT  = 2'd0,
        FMT_ZEXT  = 2'd1,
        FMT_BRIEF = 2'd2,
        FMT_PAIR  = 2'd3
    } ext_fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WORD_A = 2'd1,
        ST_WORD_B = 2'd2,
        ST_DONE   = 2'd3
    } dec_state_e;

endpackage

// File: rtl/ea_sign_ext.sv
module ea_sign_ext #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  in_i,
    output logic [OUT_W-1:0] out_o
);
    localparam int PAD_W = OUT_W - IN_W;

    generate
        if (PAD_W > 0) begin : g_pad
            assign out_o = {{PAD_W{in_i[IN_W-1]}}, in_i};
        end else begin : g_nopad
            assign out_o = in_i[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/ea_mode_classify.sv
module ea_mode_classify
    import ea_ext_pkg::*;
(
    input  logic [2:0] mode_i,
    input  logic [2:0] reg_i,
    input  op_size_e   size_i,
    output ea_kind_e   kind_o,
    output logic [1:0] nwords_o,
    output ext_fmt_e   fmt_o,
    output logic       illegal_o
);
    always_comb begin
        kind_o    = K_NONE;
        nwords_o  = 2'd0;
        fmt_o     = FMT_SEXT;
        illegal_o = 1'b0;
        unique case (mode_i)
            3'd0: kind_o = K_DREG;
            3'd1: kind_o = K_AREG;
            3'd2: kind_o = K_IND;
            3'd3: kind_o = K_POSTINC;
            3'd4: kind_o = K_PREDEC;
            3'd5: begin
                kind_o   = K_DISP;
                nwords_o = 2'd1;
                fmt_o    = FMT_SEXT;
            end
            3'd6: begin
                kind_o   = K_INDEX;
                nwords_o = 2'd1;
                fmt_o    = FMT_BRIEF;
            end
            default: begin
                unique case (reg_i)
                    3'd0: begin
                        kind_o   = K_ABS16;
                        nwords_o = 2'd1;
                        fmt_o    = FMT_SEXT;
                    end
                    3'd1: begin
                        kind_o   = K_ABS32;
                        nwords_o = 2'd2;
                        fmt_o    = FMT_PAIR;
                    end
                    3'd2: begin
                        kind_o   = K_PCDISP;
                        nwords_o = 2'd1;
                        fmt_o    = FMT_SEXT;
                    end
                    3'd3: begin
                        kind_o   = K_PCINDEX;
                        nwords_o = 2'd1;
                        fmt_o    = FMT_BRIEF;
                    end
                    3'd4: begin
                        unique case (size_i)
                            SZ_LONG: begin
                                kind_o   = K_IMM;
                                nwords_o = 2'd2;
                                fmt_o    = FMT_PAIR;
                            end
                            SZ_NONE: begin
                                illegal_o = 1'b1;
                            end
                            default: begin
                                kind_o   = K_IMM;
                                nwords_o = 2'd1;
                                fmt_o    = FMT_ZEXT;
                            end
                        endcase
                    end
                    default: illegal_o = 1'b1;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/ea_brief_unpack.sv
module ea_brief_unpack #(
    parameter int VAL_W = 32
) (
    input  logic [4:0]       hdr_i,   // brief word bits 15:11
    input  logic [7:0]       disp_i,  // brief word bits 7:0
    output logic             idx_is_addr_o,
    output logic [2:0]       idx_reg_o,
    output logic             idx_long_o,
    output logic [VAL_W-1:0] disp_o
);
    assign idx_is_addr_o = hdr_i[4];
    assign idx_reg_o     = hdr_i[3:1];
    assign idx_long_o    = hdr_i[0];

    ea_sign_ext #(.IN_W(8), .OUT_W(VAL_W)) i_disp_ext (
        .in_i  (disp_i),
        .out_o (disp_o)
    );
endmodule

// File: rtl/ea_ext_decoder.sv
module ea_ext_decoder
    import ea_ext_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [2:0]          mode_i,
    input  logic [2:0]          reg_i,
    input  logic [1:0]          size_i,
    input  logic                ext_valid_i,
    input  logic [WORD_W-1:0]   ext_data_i,
    output logic                ext_ready_o,
    output logic                done_o,
    output logic                err_o,
    output logic [3:0]          kind_o,
    output logic [2:0]          base_reg_o,
    output logic [2*WORD_W-1:0] value_o,
    output logic                idx_is_addr_o,
    output logic [2:0]          idx_reg_o,
    output logic                idx_long_o
);
    localparam int VAL_W = 2 * WORD_W;

    dec_state_e state_q, state_d;

    ea_kind_e   cls_kind;
    logic [1:0] cls_nwords;
    ext_fmt_e   cls_fmt;
    logic       cls_illegal;

    ea_kind_e   kind_q;
    logic [2:0] base_q;
    logic [VAL_W-1:0] value_q;
    logic       err_q;
    logic       ia_q, il_q;
    logic [2:0] ir_q;
    ext_fmt_e   fmt_q;
    logic       two_q;

    logic [VAL_W-1:0] word_sext;
    logic [VAL_W-1:0] brief_disp;
    logic       brief_ia, brief_il;
    logic [2:0] brief_ir;

    logic accept_start, take_a, take_b;

    ea_mode_classify i_classify (
        .mode_i    (mode_i),
        .reg_i     (reg_i),
        .size_i    (op_size_e'(size_i)),
        .kind_o    (cls_kind),
        .nwords_o  (cls_nwords),
        .fmt_o     (cls_fmt),
        .illegal_o (cls_illegal)
    );

    ea_sign_ext #(.IN_W(WORD_W), .OUT_W(VAL_W)) i_word_ext (
        .in_i  (ext_data_i),
        .out_o (word_sext)
    );

    ea_brief_unpack #(.VAL_W(VAL_W)) i_brief (
        .hdr_i         (ext_data_i[15:11]),
        .disp_i        (ext_data_i[7:0]),
        .idx_is_addr_o (brief_ia),
        .idx_reg_o     (brief_ir),
        .idx_long_o    (brief_il),
        .disp_o        (brief_disp)
    );

    assign accept_start = (state_q == ST_IDLE) && start_i;
    assign take_a       = (state_q == ST_WORD_A) && ext_valid_i;
    assign take_b       = (state_q == ST_WORD_B) && ext_valid_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (cls_illegal || (cls_nwords == 2'd0)) state_d = ST_DONE;
                    else                                     state_d = ST_WORD_A;
                end
            end
            ST_WORD_A: begin
                if (ext_valid_i) state_d = two_q ? ST_WORD_B : ST_DONE;
            end
            ST_WORD_B: begin
                if (ext_valid_i) state_d = ST_DONE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        ext_ready_o = 1'b0;
        done_o      = 1'b0;
        unique case (state_q)
            ST_WORD_A, ST_WORD_B: ext_ready_o = 1'b1;
            ST_DONE:              done_o      = 1'b1;
            default: ;
        endcase
    end

    // Descriptor datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= K_NONE;
            base_q  <= '0;
            value_q <= '0;
            err_q   <= 1'b0;
            ia_q    <= 1'b0;
            ir_q    <= '0;
            il_q    <= 1'b0;
            fmt_q   <= FMT_SEXT;
            two_q   <= 1'b0;
        end else if (accept_start) begin
            kind_q  <= cls_illegal ? K_NONE : cls_kind;
            base_q  <= (mode_i == 3'd7) ? 3'd0 : reg_i;
            value_q <= '0;
            err_q   <= cls_illegal;
            ia_q    <= 1'b0;
            ir_q    <= '0;
            il_q    <= 1'b0;
            fmt_q   <= cls_fmt;
            two_q   <= (cls_nwords == 2'd2);
        end else if (take_a) begin
            unique case (fmt_q)
                FMT_SEXT: value_q <= word_sext;
                FMT_ZEXT: value_q <= {{WORD_W{1'b0}}, ext_data_i};
                FMT_PAIR: value_q <= {ext_data_i, {WORD_W{1'b0}}};
                default: begin
                    value_q <= brief_disp;
                    ia_q    <= brief_ia;
                    ir_q    <= brief_ir;
                    il_q    <= brief_il;
                end
            endcase
        end else if (take_b) begin
            value_q[WORD_W-1:0] <= ext_data_i;
        end
    end

    assign err_o         = err_q;
    assign kind_o        = kind_q;
    assign base_reg_o    = base_q;
    assign value_o       = value_q;
    assign idx_is_addr_o = ia_q;
    assign idx_reg_o     = ir_q;
    assign idx_long_o    = il_q;

    // R9: completion pulse lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: descriptor held while idle without a start
    a_r9_desc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_i) |=> ($stable(value_o) && $stable(kind_o) && $stable(err_o)));

    // R8: immediate without a size completes at once with an error
    a_r8_imm_nosize: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && mode_i == 3'd7 && reg_i == 3'd4 && size_i == 2'd3)
        |=> (done_o && err_o));

    // R8: an erroring operation never passed through a fetch state
    a_r8_err_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> $past(state_q == ST_IDLE));

    // R10: a start while busy leaves the operand kind unchanged
    a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start_i) |=> $stable(kind_o));

    // R11: without valid, nothing is taken and the wait continues
    a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_ready_o && !ext_valid_i) |=> ($stable(value_o) && ext_ready_o));

endmodule

// File: tb/test_ea_ext_decoder.sv
module test_ea_ext_decoder;
    localparam int WORD_W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [2:0]  reg_i = '0;
    logic [1:0]  size_i = '0;
    logic        ext_valid_i = 1'b0;
    logic [15:0] ext_data_i = '0;
    logic        ext_ready_o, done_o, err_o;
    logic [3:0]  kind_o;
    logic [2:0]  base_reg_o;
    logic [31:0] value_o;
    logic        idx_is_addr_o, idx_long_o;
    logic [2:0]  idx_reg_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    ea_ext_decoder #(.WORD_W(WORD_W)) i_ea_ext_decoder (
        .clk, .rst_n, .start_i, .mode_i, .reg_i, .size_i,
        .ext_valid_i, .ext_data_i, .ext_ready_o, .done_o, .err_o,
        .kind_o, .base_reg_o, .value_o, .idx_is_addr_o, .idx_reg_o, .idx_long_o
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    int  used;
    bit  rdy_seen;
    bit  timed_out;

    task automatic do_op(input logic [2:0] m, input logic [2:0] r, input logic [1:0] s,
                         input logic [15:0] w0, input logic [15:0] w1,
                         input int gap, input bit poke);
        int cyc = 0;
        bit hs;
        used = 0; rdy_seen = 0; timed_out = 0;
        @(negedge clk);
        start_i = 1'b1; mode_i = m; reg_i = r; size_i = s;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && cyc < 50) begin
            start_i = (poke && cyc == 0) ? 1'b1 : 1'b0;
            if (poke && cyc == 0) begin mode_i = 3'd0; reg_i = 3'd6; end
            if (ext_ready_o) rdy_seen = 1;
            ext_valid_i = ext_ready_o && (cyc >= gap);
            ext_data_i  = (used == 0) ? w0 : w1;
            hs = ext_ready_o && ext_valid_i;
            @(negedge clk);
            if (hs) used++;
            cyc++;
        end
        start_i = 1'b0;
        ext_valid_i = 1'b0;
        if (!done_o) timed_out = 1;
    endtask

    // Checks at the done cycle, then that done falls and the descriptor holds
    task automatic chk_desc(input string tag, input logic [3:0] k, input logic [2:0] b,
                            input logic [31:0] v, input logic e, input int nw);
        logic [31:0] v_at_done;
        chk({tag, " done seen"}, {31'd0, timed_out}, 32'd0);
        chk({tag, " kind"},  {28'd0, kind_o}, {28'd0, k});
        chk({tag, " base"},  {29'd0, base_reg_o}, {29'd0, b});
        chk({tag, " value"}, value_o, v);
        chk({tag, " err"},   {31'd0, err_o}, {31'd0, e});
        chk({tag, " words"}, used, nw);
        v_at_done = value_o;
        @(negedge clk);
        chk({tag, " R9 done one cycle"}, {31'd0, done_o}, 32'd0);
        chk({tag, " R9 value held"}, value_o, v_at_done);
    endtask

    task automatic t_reset();
        chk("R1 done", {31'd0, done_o}, 0);
        chk("R1 ready", {31'd0, ext_ready_o}, 0);
        chk("R1 err", {31'd0, err_o}, 0);
        chk("R1 kind", {28'd0, kind_o}, 32'd15);
        chk("R1 value", value_o, 0);
        chk("R1 index", {27'd0, idx_is_addr_o, idx_reg_o, idx_long_o}, 0);
    endtask

    task automatic t_direct();
        for (int m = 0; m < 5; m++) begin
            do_op(3'(m), 3'd5, 2'd1, 16'h0, 16'h0, 0, 0);
            chk_desc("R2 direct", 4'(m), 3'd5, 32'h0, 1'b0, 0);
        end
    endtask

    task automatic t_disp();
        do_op(3'd5, 3'd3, 2'd0, 16'hFFFE, 16'h0, 0, 0);
        chk_desc("R3 neg disp", 4'd5, 3'd3, 32'hFFFF_FFFE, 1'b0, 1);
        do_op(3'd5, 3'd4, 2'd2, 16'h1234, 16'h0, 0, 0);
        chk_desc("R3 pos disp", 4'd5, 3'd4, 32'h0000_1234, 1'b0, 1);
    endtask

    task automatic t_index();
        do_op(3'd6, 3'd2, 2'd1, 16'hB880, 16'h0, 0, 0);
        chk_desc("R4 addr long idx", 4'd6, 3'd2, 32'hFFFF_FF80, 1'b0, 1);
        chk("R4 idx fields a", {27'd0, idx_is_addr_o, idx_reg_o, idx_long_o}, {27'd0, 1'b1, 3'd3, 1'b1});
        do_op(3'd6, 3'd7, 2'd1, 16'h2742, 16'h0, 0, 0);
        chk_desc("R4 data word idx", 4'd6, 3'd7, 32'h0000_0042, 1'b0, 1);
        chk("R4 idx fields b", {27'd0, idx_is_addr_o, idx_reg_o, idx_long_o}, {27'd0, 1'b0, 3'd2, 1'b0});
    endtask

    task automatic t_abs();
        do_op(3'd7, 3'd0, 2'd1, 16'h8000, 16'h0, 0, 0);
        chk_desc("R5 abs short", 4'd7, 3'd0, 32'hFFFF_8000, 1'b0, 1);
        do_op(3'd7, 3'd1, 2'd1, 16'h1234, 16'hABCD, 2, 0);
        chk_desc("R5 R11 abs long stalled", 4'd8, 3'd0, 32'h1234_ABCD, 1'b0, 2);
    endtask

    task automatic t_pc();
        do_op(3'd7, 3'd2, 2'd3, 16'h7FFF, 16'h0, 0, 0);
        chk_desc("R6 pc disp", 4'd9, 3'd0, 32'h0000_7FFF, 1'b0, 1);
        do_op(3'd7, 3'd3, 2'd3, 16'h70FF, 16'h0, 0, 0);
        chk_desc("R6 pc index", 4'd10, 3'd0, 32'hFFFF_FFFF, 1'b0, 1);
        chk("R6 idx fields", {27'd0, idx_is_addr_o, idx_reg_o, idx_long_o}, {27'd0, 1'b0, 3'd7, 1'b0});
    endtask

    task automatic t_imm();
        do_op(3'd7, 3'd4, 2'd0, 16'h00F5, 16'h0, 0, 0);
        chk_desc("R7 imm byte", 4'd11, 3'd0, 32'h0000_00F5, 1'b0, 1);
        do_op(3'd7, 3'd4, 2'd1, 16'h8001, 16'h0, 0, 0);
        chk_desc("R7 imm word zero-ext", 4'd11, 3'd0, 32'h0000_8001, 1'b0, 1);
        do_op(3'd7, 3'd4, 2'd2, 16'hDEAD, 16'hBEEF, 0, 0);
        chk_desc("R7 imm long", 4'd11, 3'd0, 32'hDEAD_BEEF, 1'b0, 2);
    endtask

    task automatic t_illegal();
        for (int r = 5; r < 8; r++) begin
            do_op(3'd7, 3'(r), 2'd1, 16'h5555, 16'h0, 0, 0);
            chk("R8 ready never high", {31'd0, rdy_seen}, 0);
            chk_desc("R8 illegal reg", 4'd15, 3'd0, 32'h0, 1'b1, 0);
        end
        do_op(3'd7, 3'd4, 2'd3, 16'h5555, 16'h0, 0, 0);
        chk("R8 imm nosize ready", {31'd0, rdy_seen}, 0);
        chk_desc("R8 imm no size", 4'd15, 3'd0, 32'h0, 1'b1, 0);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        do_op(3'd5, 3'd0, 2'd1, 16'hC001, 16'h0, 0, 0);
        chk_desc("R9 hold op", 4'd5, 3'd0, 32'hFFFF_C001, 1'b0, 1);
        v = value_o;
        mode_i = 3'd7; reg_i = 3'd1; ext_data_i = 16'h9999;
        repeat (3) @(negedge clk);
        chk("R9 value after idle", value_o, v);
        chk("R9 kind after idle", {28'd0, kind_o}, 32'd5);
    endtask

    task automatic t_busy();
        do_op(3'd5, 3'd1, 2'd1, 16'h0010, 16'h0, 1, 1);
        chk_desc("R10 start while busy", 4'd5, 3'd1, 32'h0000_0010, 1'b0, 1);
    endtask

    initial begin
        #(20 * 200000);
        n_fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_direct();
        t_disp();
        t_index();
        t_abs();
        t_pc();
        t_imm();
        t_illegal();
        t_hold();
        t_busy();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule